// File: doc/BRIEF.md
# Line-Invalidate Store Backup Queue

This block holds an ordered list of stores that were written to cacheable addresses by a store-with-allocate operation, before the line they touch is known to be safe in memory. Each accepted record request takes a slot at the tail, so entries stay in arrival order. When a cache line is invalidated, the block looks for recorded stores that fall in the same 32-byte line. It takes the oldest of them, presents its full address and data on a memory-write port with a valid/ready handshake, and deletes it from the list. The entries behind the deleted one move up one slot, so their relative order does not change.

A discard strobe empties the list and writes nothing back. Record requests that are not marked cacheable are ignored. A cacheable request that arrives while all slots are full is dropped and raises a one-cycle overflow pulse. While a write-out is waiting for its handshake, the invalidate port reports not-ready.

Top module: `line_inval_store_queue`

## Requirements
- R1: After reset the list is empty, `wr_valid_o` and `overflow_o` are 0, and `inv_ready_o` is 1.
- R2: A record request with `rec_cacheable_i` = 0 is not stored, so a later invalidate of its line produces no write-out.
- R3: An invalidate matches an entry when address bits [31:5] are equal. Bits [4:0] of both addresses are ignored.
- R4: When an accepted invalidate (`inv_valid_i` and `inv_ready_o` both 1 at a clock edge) has matches, `wr_valid_o` is 1 from the next cycle. `wr_addr_o` and `wr_data_o` then carry the full stored address and data of the oldest matching entry.
- R5: The entry that was written out is removed, and exactly one entry is removed per invalidate. Later invalidates of the same line return the remaining matches oldest-first, even after an entry was removed from the middle of the list.
- R6: An invalidate with no match produces no write-out and leaves `inv_ready_o` at 1.
- R7: While `wr_valid_o` = 1 and `wr_ready_i` = 0, `wr_addr_o` and `wr_data_o` stay unchanged and `inv_ready_o` is 0. `wr_valid_o` falls the cycle after a handshake.
- R8: `discard_i` removes every entry without any write-out. It takes priority over a record or an invalidate in the same cycle.
- R9: The list holds DEPTH entries (8 by default). A cacheable record while full is dropped, and `overflow_o` is 1 for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record request strobe |
| rec_addr_i | input | 32 | Store address |
| rec_data_i | input | 32 | Store data |
| rec_cacheable_i | input | 1 | Address is cacheable |
| inv_valid_i | input | 1 | Line invalidate request |
| inv_addr_i | input | 32 | Address inside the invalidated line |
| inv_ready_o | output | 1 | Invalidate can be accepted |
| discard_i | input | 1 | Empty the list without write-back |
| wr_valid_o | output | 1 | Write-out pending |
| wr_addr_o | output | 32 | Write-out address |
| wr_data_o | output | 32 | Write-out data |
| wr_ready_i | input | 1 | Memory accepts the write |
| overflow_o | output | 1 | Cacheable record dropped because the list was full |

## Verification
Several stores are recorded in interleaved lines, with different byte offsets inside the same line, so that only a comparison on bits [31:5] can return the right entries. Repeated invalidates of one line show that matches come out oldest-first and one per request, also after an entry has been removed from the middle of the list. A non-cacheable record, a discard on its own and a discard in the same cycle as a record are each followed by invalidates of the affected lines, which must all miss. The list is filled to capacity and one more record is sent: the overflow pulse must appear, the extra store must be absent, and the oldest stored entry must still be present.

// File: rtl/lisq_pkg.sv
package lisq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/lisq_match.sv
module lisq_match
  import lisq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  entry_t            ents_i [DEPTH],
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  sel_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (CNT_W'(g) < count_i) &&
                      (ents_i[g].addr[ADDR_W-1:LINE_W] == inv_addr_i[ADDR_W-1:LINE_W]);
  end

  // lowest index = oldest entry wins
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        sel_o = IDX_W'(i);
      end
    end
  end

  p_sel_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (CNT_W'(sel_o) < count_i));
  p_sel_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ents_i[sel_o].addr[ADDR_W-1:LINE_W] == inv_addr_i[ADDR_W-1:LINE_W]));
endmodule

// File: rtl/lisq_store.sv
module lisq_store
  import lisq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  entry_t           push_ent_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  input  logic             clr_i,
  output entry_t           ents_o [DEPTH],
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  entry_t           ents_q [DEPTH];
  entry_t           ents_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, accept, drop;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = push_i && !clr_i && !full;
  assign drop   = push_i && !clr_i && full;

  always_comb begin
    ents_d = ents_q;
    cnt_d  = cnt_q;
    if (pop_i) begin
      // close the gap, keep order
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx_i) ents_d[i] = ents_q[i+1];
      end
      cnt_d = cnt_q - 1'b1;
    end
    if (accept) begin
      ents_d[cnt_d[IDX_W-1:0]] = push_ent_i;
      cnt_d = cnt_d + 1'b1;
    end
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      overflow_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ents_q[i] <= '0;
    end else begin
      cnt_q      <= cnt_d;
      overflow_o <= drop;
      ents_q     <= ents_d;
    end
  end

  assign ents_o  = ents_q;
  assign count_o = cnt_q;

  p_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i && full) |=> overflow_o);
  p_discard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lisq_wrout.sv
module lisq_wrout
  import lisq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  entry_t            ent_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else if (load_i) begin
      wr_valid_o <= 1'b1;
      wr_addr_o  <= ent_i.addr;
      wr_data_o  <= ent_i.data;
    end else if (wr_ready_i) begin
      wr_valid_o <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  p_no_overwrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |-> !load_i);
endmodule

// File: rtl/line_inval_store_queue.sv
module line_inval_store_queue
  import lisq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  input  logic [DATA_W-1:0] rec_data_i,
  input  logic              rec_cacheable_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              inv_ready_o,
  input  logic              discard_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              overflow_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t           ents [DEPTH];
  logic [CNT_W-1:0] count;
  logic             hit, pop, push;
  logic [IDX_W-1:0] sel;
  entry_t           rec_ent;

  assign inv_ready_o = !wr_valid_o;
  assign push        = rec_valid_i && rec_cacheable_i;
  assign pop         = inv_valid_i && inv_ready_o && hit && !discard_i;
  assign rec_ent     = '{addr: rec_addr_i, data: rec_data_i};

  lisq_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_match (
    .clk_i, .rst_ni,
    .ents_i(ents), .count_i(count), .inv_addr_i(inv_addr_i),
    .hit_o(hit), .sel_o(sel)
  );

  lisq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .push_ent_i(rec_ent),
    .pop_i(pop), .pop_idx_i(sel), .clr_i(discard_i),
    .ents_o(ents), .count_o(count), .overflow_o(overflow_o)
  );

  lisq_wrout u_wrout (
    .clk_i, .rst_ni,
    .load_i(pop), .ent_i(ents[sel]), .wr_ready_i(wr_ready_i),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  p_noncache_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && !rec_cacheable_i && !(inv_valid_i && inv_ready_o) && !discard_i)
      |=> $stable(count));
  p_discard_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_i && !wr_valid_o) |=> !wr_valid_o);
  p_miss_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_ready_o && !hit) |=> !wr_valid_o);
endmodule

// File: tb/tb_line_inval_store_queue.sv
module tb_line_inval_store_queue;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rec_valid_i = 1'b0, rec_cacheable_i = 1'b0;
  logic [31:0] rec_addr_i = '0, rec_data_i = '0, inv_addr_i = '0;
  logic        inv_valid_i = 1'b0, discard_i = 1'b0, wr_ready_i = 1'b0;
  logic        inv_ready_o, wr_valid_o, overflow_o;
  logic [31:0] wr_addr_o, wr_data_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  line_inval_store_queue dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic record(input logic [31:0] a, input logic [31:0] d, input logic c);
    rec_valid_i = 1'b1; rec_addr_i = a; rec_data_i = d; rec_cacheable_i = c;
    @(negedge clk_i);
    rec_valid_i = 1'b0; rec_cacheable_i = 1'b0;
  endtask

  // invalidate, check result, then complete the write handshake
  task automatic inval(input string tag, input logic [31:0] a, input logic hit,
                       input logic [31:0] ea, input logic [31:0] ed);
    inv_valid_i = 1'b1; inv_addr_i = a;
    @(negedge clk_i);
    inv_valid_i = 1'b0;
    chk({tag, " valid"}, 32'(wr_valid_o), 32'(hit));
    if (hit) begin
      chk({tag, " addr"}, wr_addr_o, ea);
      chk({tag, " data"}, wr_data_o, ed);
      wr_ready_i = 1'b1;
      @(negedge clk_i);
      wr_ready_i = 1'b0;
      chk({tag, " released"}, 32'(wr_valid_o), 32'd0);
    end else begin
      chk({tag, " ready"}, 32'(inv_ready_o), 32'd1);
    end
  endtask

  task automatic t_reset;
    chk("R1 wr_valid", 32'(wr_valid_o), 0);
    chk("R1 overflow", 32'(overflow_o), 0);
    chk("R1 inv_ready", 32'(inv_ready_o), 1);
    inval("R1 empty", 32'h40, 1'b0, 0, 0);
  endtask

  task automatic t_noncache;
    record(32'h0000_0100, 32'hDEAD_0001, 1'b0);
    inval("R2 noncacheable", 32'h0000_0100, 1'b0, 0, 0);
  endtask

  task automatic t_line_match;
    record(32'h0000_1004, 32'hA, 1'b1);
    record(32'h0000_2000, 32'hB, 1'b1);
    record(32'h0000_101C, 32'hC, 1'b1);
    inval("R3 offset ignored", 32'h0000_1010, 1'b1, 32'h0000_1004, 32'hA);
    inval("R5 next oldest", 32'h0000_1000, 1'b1, 32'h0000_101C, 32'hC);
    inval("R6 miss after drain", 32'h0000_101F, 1'b0, 0, 0);
    inval("R4 other line", 32'h0000_201F, 1'b1, 32'h0000_2000, 32'hB);
  endtask

  task automatic t_order;
    record(32'h0000_0020, 32'h1, 1'b1);
    record(32'h0000_0044, 32'h2, 1'b1);
    record(32'h0000_0028, 32'h3, 1'b1);
    record(32'h0000_0048, 32'h4, 1'b1);
    inval("R5 l1 first", 32'h0000_0020, 1'b1, 32'h0000_0020, 32'h1);
    inval("R5 l2 first", 32'h0000_0040, 1'b1, 32'h0000_0044, 32'h2);
    inval("R5 l1 second", 32'h0000_0020, 1'b1, 32'h0000_0028, 32'h3);
    inval("R5 l2 second", 32'h0000_0040, 1'b1, 32'h0000_0048, 32'h4);
  endtask

  task automatic t_hold;
    record(32'h0000_3008, 32'h77, 1'b1);
    inv_valid_i = 1'b1; inv_addr_i = 32'h0000_3000;
    @(negedge clk_i);
    inv_valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R7 held valid", 32'(wr_valid_o), 1);
      chk("R7 held addr", wr_addr_o, 32'h0000_3008);
      chk("R7 held data", wr_data_o, 32'h77);
      chk("R7 inv blocked", 32'(inv_ready_o), 0);
    end
    wr_ready_i = 1'b1;
    @(negedge clk_i);
    wr_ready_i = 1'b0;
    chk("R7 released", 32'(wr_valid_o), 0);
  endtask

  task automatic t_discard;
    record(32'h0000_4000, 32'h11, 1'b1);
    record(32'h0000_4020, 32'h12, 1'b1);
    discard_i = 1'b1;
    @(negedge clk_i);
    discard_i = 1'b0;
    chk("R8 no write on discard", 32'(wr_valid_o), 0);
    inval("R8 gone a", 32'h0000_4000, 1'b0, 0, 0);
    inval("R8 gone b", 32'h0000_4020, 1'b0, 0, 0);
    discard_i = 1'b1;
    record(32'h0000_4040, 32'h13, 1'b1);
    discard_i = 1'b0;
    inval("R8 same-cycle record dropped", 32'h0000_4040, 1'b0, 0, 0);
  endtask

  task automatic t_full;
    for (int k = 0; k < 8; k++) record(32'h0001_0000 + 32'(k) * 32'h20, 32'h100 + 32'(k), 1'b1);
    chk("R9 no early overflow", 32'(overflow_o), 0);
    record(32'h0005_0000, 32'hBAD, 1'b1);
    chk("R9 overflow pulse", 32'(overflow_o), 1);
    @(negedge clk_i);
    chk("R9 overflow one cycle", 32'(overflow_o), 0);
    inval("R9 dropped entry absent", 32'h0005_0000, 1'b0, 0, 0);
    inval("R9 oldest kept", 32'h0001_0000, 1'b1, 32'h0001_0000, 32'h100);
    inval("R9 newest kept", 32'h0001_00E0, 1'b1, 32'h0001_00E0, 32'h107);
    discard_i = 1'b1;
    @(negedge clk_i);
    discard_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_noncache;
    t_line_match;
    t_order;
    t_hold;
    t_discard;
    t_full;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule